// File: doc/BRIEF.md
# Stream-Cipher Size Register Sequencer

This block is the control logic behind the size register of a stream-cipher execution unit. The host writes one register for two purposes. A write of the fixed context length (2072 bits, or 259 bytes) tells the unit that a saved context is already in the input FIFO. Any other write gives the bit length of the message. Every write is checked for byte alignment on its three low bits only, so the host may write the full message length. The stored length saturates at 4096 bits.

After a valid message-size write the sequencer is armed. It waits for the input FIFO to hold data, then gives the datapath a one-cycle start pulse and stays busy until the datapath reports done. From the written length it derives how many bytes of the last block (1 to 8) the datapath must process. If the size is changed while a message is armed or being processed, a sticky context error is raised. A context-size write made before the FIFO holds the whole context raises the same error. Reset and reinitialisation both return the block to its cleared state.

Top module: `szseq_top`

## Requirements
- R1: After `rst` or `reinit`, the stored size reads 0, both error outputs are 0, `start` is 0, and the status word reads 0.
- R2: A write whose `wr_data[2:0]` is nonzero sets `size_err`. It leaves the stored size unchanged, does not arm the sequencer, and never leads to a `start` pulse.
- R3: Only `wr_data[2:0]` decides alignment, so any multiple of 8 raises no size error. An accepted write stores min(`wr_data`, 4096).
- R4: On an accepted message-size write, `tail_bytes` takes the value `wr_data[5:3]`, or 8 when that field is 0, and holds it until the next accepted message write.
- R5: While idle with no context loaded, a write of exactly 2072 is a context-size write. If `fifo_bytes` is at least 259, it sets the context-loaded status bit. Otherwise it sets `ctx_err`. In neither case does it arm the sequencer or produce a `start` pulse.
- R6: Once a context is loaded, the next write is taken as the message size, even when its value is 2072, and it arms the sequencer.
- R7: While armed, the sequencer waits as long as `fifo_bytes` is 0. At the first clock edge that sees the sequencer armed with `fifo_bytes` nonzero, it raises `start` for exactly one cycle and becomes busy.
- R8: Busy holds until a clock edge sees `dp_done`. That edge returns the sequencer to idle and clears the context-loaded bit.
- R9: While armed or busy, a write of a value different from the stored size sets `ctx_err` and leaves the stored size unchanged. A write of the same value has no effect.
- R10: With `rd_sel`=1, `rd_data` holds the status word: bit0 `size_err`, bit1 `ctx_err`, bit2 context loaded, bit3 armed, bit4 busy, and all higher bits 0. With `rd_sel`=0, it holds the stored size, zero-extended.
- R11: `size_err` and `ctx_err` stay set until `rst` or `reinit`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reinit | input | 1 | Synchronous reinitialisation, same effect as reset |
| wr_en | input | 1 | Size register write strobe |
| wr_data | input | DATA_W | Written size in bits |
| rd_sel | input | 1 | Read select: 0 size, 1 status |
| rd_data | output | DATA_W | Read data |
| fifo_bytes | input | FIFO_W | Input FIFO fill level in bytes |
| dp_done | input | 1 | Datapath finished the message |
| start | output | 1 | One-cycle start pulse to the datapath |
| tail_bytes | output | 4 | Bytes to process from the last block, 1 to 8 |
| size_err | output | 1 | Sticky alignment error |
| ctx_err | output | 1 | Sticky context error |

## Verification
Two events can land on the same clock edge. One is a host write of a changed size. The other is the datapath's done that ends the busy state. The bench drives `dp_done` and a write of a different value in the same cycle while the sequencer is busy. The write must count as a change during processing: `ctx_err` is set and the stored size is kept. The sequencer must still return to idle and clear its context-loaded bit. Both results are read back through the status and size words.

// File: rtl/szseq_pkg.sv
package szseq_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ARMED = 2'd1,
        ST_BUSY  = 2'd2
    } seq_state_e;

    typedef struct packed {
        logic       align_bad;
        logic       ctx_kind;
        logic [3:0] tail;
    } wr_class_t;

    localparam int NUM_FLAGS = 2;
    localparam int FLAG_SIZE = 0;
    localparam int FLAG_CTX  = 1;

    function automatic logic [3:0] tail_len(input logic [2:0] blk);
        return (blk == 3'd0) ? 4'd8 : {1'b0, blk};
    endfunction

endpackage

// File: rtl/szseq_decode.sv
module szseq_decode
    import szseq_pkg::*;
#(
    parameter int DATA_W   = 16,
    parameter int MAX_BITS = 4096,
    parameter int CTX_BITS = 2072,
    parameter int STORE_W  = 13
) (
    input  logic [DATA_W-1:0]  wr_data,
    input  logic               ctx_loaded,
    output wr_class_t          cls,
    output logic [STORE_W-1:0] sat_size
);
    localparam int CMP_W = (DATA_W > STORE_W) ? DATA_W : STORE_W;

    logic [CMP_W-1:0] wide;

    always_comb begin
        wide          = CMP_W'(wr_data);
        cls.align_bad = (wr_data[2:0] != 3'd0);
        cls.ctx_kind  = !ctx_loaded && (wr_data == DATA_W'(CTX_BITS));
        cls.tail      = tail_len(wr_data[5:3]);
        if (wide > CMP_W'(MAX_BITS))
            sat_size = STORE_W'(MAX_BITS);
        else
            sat_size = STORE_W'(wide);
    end

endmodule

// File: rtl/szseq_flags.sv
module szseq_flags
    import szseq_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 reinit,
    input  logic [NUM_FLAGS-1:0] set_evt,
    output logic [NUM_FLAGS-1:0] flags
);
    for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_flag
        always_ff @(posedge clk) begin
            if (rst || reinit)
                flags[i] <= 1'b0;
            else if (set_evt[i])
                flags[i] <= 1'b1;
        end
    end

endmodule

// File: rtl/szseq_ctrl.sv
module szseq_ctrl
    import szseq_pkg::*;
#(
    parameter int STORE_W = 13
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               reinit,
    input  logic               wr_en,
    input  wr_class_t          cls,
    input  logic [STORE_W-1:0] sat_size,
    input  logic               fifo_nonempty,
    input  logic               fifo_ctx_ok,
    input  logic               dp_done,
    output seq_state_e         state,
    output logic [STORE_W-1:0] size_q,
    output logic [3:0]         tail_q,
    output logic               ctx_loaded,
    output logic               start,
    output logic               evt_size,
    output logic               evt_ctx
);
    logic in_proc;
    logic idle_wr_ok;
    logic ctx_accept;
    logic msg_accept;

    always_comb begin
        in_proc    = (state != ST_IDLE);
        idle_wr_ok = wr_en && !in_proc && !cls.align_bad;
        ctx_accept = idle_wr_ok && cls.ctx_kind && fifo_ctx_ok;
        msg_accept = idle_wr_ok && !cls.ctx_kind;
        evt_size   = wr_en && cls.align_bad;
        evt_ctx    = wr_en && ((in_proc && (sat_size != size_q)) ||
                               (!in_proc && cls.ctx_kind && !fifo_ctx_ok));
    end

    always_ff @(posedge clk) begin
        if (rst || reinit) begin
            state      <= ST_IDLE;
            size_q     <= '0;
            tail_q     <= 4'd8;
            ctx_loaded <= 1'b0;
            start      <= 1'b0;
        end else begin
            start <= 1'b0;
            if (idle_wr_ok)
                size_q <= sat_size;
            unique case (state)
                ST_IDLE: begin
                    if (ctx_accept)
                        ctx_loaded <= 1'b1;
                    if (msg_accept) begin
                        tail_q <= cls.tail;
                        state  <= ST_ARMED;
                    end
                end
                ST_ARMED: begin
                    if (fifo_nonempty) begin
                        start <= 1'b1;
                        state <= ST_BUSY;
                    end
                end
                ST_BUSY: begin
                    if (dp_done) begin
                        ctx_loaded <= 1'b0;
                        state      <= ST_IDLE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/szseq_top.sv
module szseq_top
    import szseq_pkg::*;
#(
    parameter int DATA_W   = 16,
    parameter int FIFO_W   = 10,
    parameter int MAX_BITS = 4096,
    parameter int CTX_BITS = 2072
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reinit,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_sel,
    output logic [DATA_W-1:0] rd_data,
    input  logic [FIFO_W-1:0] fifo_bytes,
    input  logic              dp_done,
    output logic              start,
    output logic [3:0]        tail_bytes,
    output logic              size_err,
    output logic              ctx_err
);
    localparam int STORE_W   = $clog2(MAX_BITS + 1);
    localparam int CTX_BYTES = CTX_BITS / 8;

    wr_class_t            cls;
    logic [STORE_W-1:0]   sat_size;
    logic [STORE_W-1:0]   size_q;
    seq_state_e           st_q;
    logic                 ctx_loaded;
    logic                 evt_size;
    logic                 evt_ctx;
    logic [NUM_FLAGS-1:0] flag_set;
    logic [NUM_FLAGS-1:0] flag_q;
    logic [4:0]           status;

    szseq_decode #(
        .DATA_W  (DATA_W),
        .MAX_BITS(MAX_BITS),
        .CTX_BITS(CTX_BITS),
        .STORE_W (STORE_W)
    ) u_decode (
        .wr_data   (wr_data),
        .ctx_loaded(ctx_loaded),
        .cls       (cls),
        .sat_size  (sat_size)
    );

    szseq_ctrl #(
        .STORE_W(STORE_W)
    ) u_ctrl (
        .clk          (clk),
        .rst          (rst),
        .reinit       (reinit),
        .wr_en        (wr_en),
        .cls          (cls),
        .sat_size     (sat_size),
        .fifo_nonempty(fifo_bytes != '0),
        .fifo_ctx_ok  (fifo_bytes >= FIFO_W'(CTX_BYTES)),
        .dp_done      (dp_done),
        .state        (st_q),
        .size_q       (size_q),
        .tail_q       (tail_bytes),
        .ctx_loaded   (ctx_loaded),
        .start        (start),
        .evt_size     (evt_size),
        .evt_ctx      (evt_ctx)
    );

    always_comb begin
        flag_set            = '0;
        flag_set[FLAG_SIZE] = evt_size;
        flag_set[FLAG_CTX]  = evt_ctx;
    end

    szseq_flags u_flags (
        .clk    (clk),
        .rst    (rst),
        .reinit (reinit),
        .set_evt(flag_set),
        .flags  (flag_q)
    );

    assign size_err = flag_q[FLAG_SIZE];
    assign ctx_err  = flag_q[FLAG_CTX];

    always_comb begin
        status  = {st_q == ST_BUSY, st_q == ST_ARMED, ctx_loaded, ctx_err, size_err};
        rd_data = rd_sel ? DATA_W'(status) : DATA_W'(size_q);
    end

endmodule

// File: rtl/szseq_sva.sv
module szseq_sva
    import szseq_pkg::*;
#(
    parameter int DATA_W  = 16,
    parameter int STORE_W = 13
) (
    input logic               clk,
    input logic               rst,
    input logic               reinit,
    input logic               wr_en,
    input logic [DATA_W-1:0]  wr_data,
    input logic               dp_done,
    input logic               start,
    input logic [3:0]         tail_bytes,
    input logic               size_err,
    input logic               ctx_err,
    input seq_state_e         st_q,
    input logic [STORE_W-1:0] size_q
);
    AST_MISALIGNED_FLAGS: assert property (@(posedge clk) disable iff (rst || reinit)
        (wr_en && wr_data[2:0] != 3'd0) |=> size_err); // R2
    AST_TAIL_IN_RANGE: assert property (@(posedge clk) disable iff (rst || reinit)
        (tail_bytes >= 4'd1 && tail_bytes <= 4'd8)); // R4
    AST_START_SINGLE: assert property (@(posedge clk) disable iff (rst || reinit)
        start |=> !start); // R7
    AST_START_FROM_ARMED: assert property (@(posedge clk) disable iff (rst || reinit)
        start |-> ($past(st_q) == ST_ARMED && st_q == ST_BUSY)); // R7
    AST_BUSY_UNTIL_DONE: assert property (@(posedge clk) disable iff (rst || reinit)
        (st_q == ST_BUSY && !dp_done) |=> st_q == ST_BUSY); // R8
    AST_SIZE_FROZEN: assert property (@(posedge clk) disable iff (rst || reinit)
        (st_q != ST_IDLE) |=> $stable(size_q)); // R9
    AST_SIZE_ERR_STICKY: assert property (@(posedge clk) disable iff (rst || reinit)
        size_err |=> size_err); // R11
    AST_CTX_ERR_STICKY: assert property (@(posedge clk) disable iff (rst || reinit)
        ctx_err |=> ctx_err); // R11
endmodule

bind szseq_top szseq_sva #(
    .DATA_W (DATA_W),
    .STORE_W(STORE_W)
) u_sva (
    .clk       (clk),
    .rst       (rst),
    .reinit    (reinit),
    .wr_en     (wr_en),
    .wr_data   (wr_data),
    .dp_done   (dp_done),
    .start     (start),
    .tail_bytes(tail_bytes),
    .size_err  (size_err),
    .ctx_err   (ctx_err),
    .st_q      (st_q),
    .size_q    (size_q)
);

// File: tb/szseq_top_test.sv
module szseq_top_test;
    localparam int DATA_W = 16;
    localparam int FIFO_W = 10;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              reinit = 1'b0;
    logic              wr_en = 1'b0;
    logic [DATA_W-1:0] wr_data = '0;
    logic              rd_sel = 1'b0;
    logic [DATA_W-1:0] rd_data;
    logic [FIFO_W-1:0] fifo_bytes = '0;
    logic              dp_done = 1'b0;
    logic              start;
    logic [3:0]        tail_bytes;
    logic              size_err;
    logic              ctx_err;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    szseq_top uut (
        .clk(clk), .rst(rst), .reinit(reinit), .wr_en(wr_en), .wr_data(wr_data),
        .rd_sel(rd_sel), .rd_data(rd_data), .fifo_bytes(fifo_bytes), .dp_done(dp_done),
        .start(start), .tail_bytes(tail_bytes), .size_err(size_err), .ctx_err(ctx_err)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic rd_size(output int v);
        rd_sel = 1'b0;
        #1 v = int'(rd_data);
    endtask

    task automatic rd_stat(output int v);
        rd_sel = 1'b1;
        #1 v = int'(rd_data);
        rd_sel = 1'b0;
    endtask

    task automatic do_write(input int v);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_data = DATA_W'(v);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic do_reinit();
        @(negedge clk);
        reinit = 1'b1;
        @(negedge clk);
        reinit = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int v;
        int s;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        rd_size(v);  chk("R1 size after reset", v, 0);
        rd_stat(s);  chk("R1 status after reset", s, 0);
        chk("R1 start after reset", int'(start), 0);
        chk("R1 errors after reset", int'({size_err, ctx_err}), 0);

        // Sweep of every written size across and beyond the storable range
        for (int w = 0; w <= 4200; w++) begin
            bit bad;
            bit is_ctx;
            bit arm;
            int exp_sz;
            int blk;
            do_reinit();
            fifo_bytes = '0;
            do_write(w);
            bad    = (w % 8) != 0;
            is_ctx = (w == 2072);
            arm    = !bad && !is_ctx;
            exp_sz = bad ? 0 : ((w > 4096) ? 4096 : w);
            blk    = (w / 8) % 8;
            chk("R2 size_err", int'(size_err), int'(bad));
            chk("R5 ctx_err on short fifo", int'(ctx_err), int'(is_ctx));
            rd_size(v); chk("R3 stored size", v, exp_sz);
            rd_stat(s); chk("R6 armed bit", (s >> 3) & 1, int'(arm));
            chk("R2 no start at write", int'(start), 0);
            if (arm) begin
                chk("R4 tail bytes", int'(tail_bytes), (blk == 0) ? 8 : blk);
                fifo_bytes = FIFO_W'(5);
                @(negedge clk);
                chk("R7 start pulse", int'(start), 1);
                rd_stat(s); chk("R10 busy bit", s, 16);
                fifo_bytes = '0;
                @(negedge clk);
                chk("R7 start single cycle", int'(start), 0);
                dp_done = 1'b1;
                @(negedge clk);
                dp_done = 1'b0;
                rd_stat(s); chk("R8 idle after done", s, 0);
            end else begin
                fifo_bytes = FIFO_W'(5);
                @(negedge clk);
                chk("R2 no start without arm", int'(start), 0);
                fifo_bytes = '0;
            end
        end

        // Context write with too little data in the FIFO
        do_reinit();
        fifo_bytes = FIFO_W'(258);
        do_write(2072);
        chk("R5 ctx_err short", int'(ctx_err), 1);
        rd_stat(s); chk("R5 status short ctx", s, 2);

        // Full context, then the message size, armed wait, busy
        do_reinit();
        rd_stat(s); chk("R1 status after reinit", s, 0);
        fifo_bytes = FIFO_W'(259);
        do_write(2072);
        chk("R5 no ctx_err", int'(ctx_err), 0);
        rd_stat(s); chk("R5 ctx loaded bit", s, 4);
        @(negedge clk);
        chk("R5 no start after ctx", int'(start), 0);
        fifo_bytes = '0;
        do_write(2072);
        rd_stat(s); chk("R6 armed with ctx", s, 12);
        chk("R4 tail of 2072", int'(tail_bytes), 3);
        repeat (3) begin
            @(negedge clk);
            chk("R7 waits on empty fifo", int'(start), 0);
        end
        do_write(2072);
        chk("R9 same value no ctx_err", int'(ctx_err), 0);
        do_write(64);
        chk("R9 changed while armed", int'(ctx_err), 1);
        rd_size(v); chk("R9 size kept", v, 2072);
        fifo_bytes = FIFO_W'(1);
        @(negedge clk);
        chk("R7 start after data", int'(start), 1);
        fifo_bytes = '0;

        // Done and a changed write on the same edge
        do_reinit();
        fifo_bytes = FIFO_W'(259);
        do_write(2072);
        do_write(1000);
        @(negedge clk);
        chk("R7 start with data present", int'(start), 1);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_data = DATA_W'(48);
        dp_done = 1'b1;
        @(negedge clk);
        wr_en   = 1'b0;
        dp_done = 1'b0;
        chk("R9 change on done edge", int'(ctx_err), 1);
        rd_size(v); chk("R9 size kept on done edge", v, 1000);
        rd_stat(s); chk("R8 idle and ctx cleared", s, 2);

        // Stickiness
        fifo_bytes = '0;
        do_write(5);
        do_write(16);
        chk("R11 size_err sticky", int'(size_err), 1);
        chk("R11 ctx_err sticky", int'(ctx_err), 1);
        rd_size(v); chk("R3 idle write stored", v, 16);
        do_reinit();
        chk("R11 cleared by reinit", int'({size_err, ctx_err}), 0);
        rd_size(v); chk("R1 size cleared by reinit", v, 0);

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule